// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the serial front end of a byte-wide memory array with a 15-bit address space. It works as an SPI mode-0 slave. The first byte after chip select falls is a command. The block then takes a two-byte start address and either streams array bytes out, MSB first, or commits incoming bytes to the array. Writes run at bus speed and need no page buffer. Each byte goes to the array as soon as its eighth bit has arrived, and the address counter advances after every byte. It wraps from the top of the space back to zero.

All serial inputs are brought into the system clock domain through a synchronizer and then oversampled. Each SCLK phase must therefore last at least six `clk` cycles. The array port is strobe based:
- A write strobe carries the address and data in the same cycle.
- A read strobe expects `mem_rdata` to be valid one cycle later.

A separate write-protect policy block supplies `wr_allow`. Its value is taken once, when a frame opens.

A hold input freezes the transfer between bits. While hold is active, the serial clock and chip select may move freely without disturbing the frame. The serial output has a separate enable so the pad can be tri-stated.

Top module: `spimem_ctrl`

## Requirements
- R1: Command 03h is a read. It is followed by two address bytes: the low 7 bits of the first byte are address bits 14..8, and the second byte is bits 7..0. Data from that address is then shifted out MSB first. Each bit changes on an SCLK falling edge, and the first data bit appears on the falling edge right after the last address bit.
- R2: Command 0Bh is a fast read. It behaves like R1, except that one dummy byte follows the address and data starts on the falling edge after the dummy byte's last bit.
- R3: The address advances by one after every data byte of a read or write and wraps from 7FFFh to 0000h.
- R4: Command 02h is a write. After the two address bytes, every complete data byte (MSB first) produces exactly one `mem_wr` pulse with its address and data, and there is no limit on the number of bytes.
- R5: A write frame produces no `mem_wr` unless the write-enable latch is set and `wr_allow` was high when chip select fell. A change of `wr_allow` later in the frame has no effect on that frame.
- R6: Command 06h, sent in its own frame, sets the write-enable latch. The latch is cleared when any frame that carried command 02h ends.
- R7: Chip select rising ends any operation, and `spi_miso_oe` goes low. A data byte with fewer than eight bits at that point is discarded and produces no `mem_wr`.
- R8: Any other command byte is a no-op. The rest of the frame produces no `mem_rd` or `mem_wr`, and `spi_miso_oe` stays low.
- R9: `spi_holdn` taken low while SCLK is low pauses the transfer. While it is paused, SCLK and chip select edges are ignored and `spi_miso_oe` is low. Taking `spi_holdn` high while SCLK is low resumes the transfer exactly where it stopped.
- R10: During read data output, `spi_mosi` is ignored and no `mem_wr` occurs.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle. Each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idle low (mode 0) |
| spi_mosi | input | 1 | Serial data into the block |
| spi_holdn | input | 1 | Hold, active low |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for the `spi_miso` pad driver |
| wr_allow | input | 1 | Write permission from the protection policy block |
| mem_addr | output | ADDR_W | Array address for the read or write strobe |
| mem_rd | output | 1 | Array read strobe; data is expected one cycle later |
| mem_wr | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data |

## Verification
Two of the block's functions can meet on the same clock: a hold request and a byte boundary. A hold can land on the low SCLK phase just after a byte's eighth rising edge, while a read prefetch, a write commit or the next output bit is still pending. The bench places hold pulses at chosen bit positions inside read and write data bytes. It toggles SCLK and chip select during the pause and then resumes. It judges the outcome at the ports: the output enable must drop during the pause, the byte read back must equal the computed array pattern, and the write log must hold exactly the intended bytes at consecutive addresses.

// File: rtl/spimem_pkg.sv
package spimem_pkg;
   localparam int unsigned BYTE_W = 8;

   localparam logic [7:0] CMD_WREN  = 8'h06;
   localparam logic [7:0] CMD_WRITE = 8'h02;
   localparam logic [7:0] CMD_READ  = 8'h03;
   localparam logic [7:0] CMD_FREAD = 8'h0B;

   typedef enum logic [2:0] {
      ST_CMD   = 3'd0,
      ST_AHI   = 3'd1,
      ST_ALO   = 3'd2,
      ST_DUMMY = 3'd3,
      ST_RDATA = 3'd4,
      ST_WDATA = 3'd5,
      ST_SKIP  = 3'd6
   } spimem_state_e;
endpackage

// File: rtl/spimem_sync.sv
module spimem_sync #(
   parameter int unsigned WIDTH     = 4,
   parameter int unsigned STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] pipe [STAGES];

   initial begin : chk_params
      assert (STAGES >= 2) else $error("spimem_sync: STAGES must be at least 2");
   end

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[0] <= RESET_VAL;
               else        pipe[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[s] <= RESET_VAL;
               else        pipe[s] <= pipe[s-1];
            end
         end
      end
   endgenerate

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/spimem_rx.sv
module spimem_rx #(
   parameter int unsigned BYTE_W    = 8,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              shift_en,
   input  logic              din,
   output logic              byte_vld,
   output logic [BYTE_W-1:0] byte_q
);
   localparam int unsigned CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

   logic [BYTE_W-1:0] sh;
   logic [BYTE_W-1:0] sh_next;
   logic [CNT_W-1:0]  cnt;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sh_next = {sh[BYTE_W-2:0], din};
      end else begin : g_lsb
         assign sh_next = {din, sh[BYTE_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh       <= '0;
         cnt      <= '0;
         byte_vld <= 1'b0;
         byte_q   <= '0;
      end else begin
         byte_vld <= 1'b0;
         if (clr) begin
            sh  <= '0;
            cnt <= '0;
         end else if (shift_en) begin
            sh <= sh_next;
            if (cnt == LAST) begin
               cnt      <= '0;
               byte_vld <= 1'b1;
               byte_q   <= sh_next;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/spimem_tx.sv
module spimem_tx #(
   parameter int unsigned BYTE_W    = 8,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_data,
   input  logic              shift,
   output logic              dout
);
   logic [BYTE_W-1:0] sh;
   logic              bit_out;
   logic [BYTE_W-1:0] sh_adv;

   generate
      if (MSB_FIRST) begin : g_msb
         assign bit_out = sh[BYTE_W-1];
         assign sh_adv  = {sh[BYTE_W-2:0], 1'b0};
      end else begin : g_lsb
         assign bit_out = sh[0];
         assign sh_adv  = {1'b0, sh[BYTE_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         dout <= 1'b0;
      end else if (clr) begin
         sh   <= '0;
         dout <= 1'b0;
      end else if (load) begin
         sh <= load_data;
      end else if (shift) begin
         dout <= bit_out;
         sh   <= sh_adv;
      end
   end
endmodule

// File: rtl/spimem_ctrl.sv
module spimem_ctrl
   import spimem_pkg::*;
#(
   parameter int unsigned ADDR_W      = 15,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_csn,
   input  logic              spi_sclk,
   input  logic              spi_mosi,
   input  logic              spi_holdn,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   input  logic              wr_allow,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [BYTE_W-1:0] mem_wdata,
   input  logic [BYTE_W-1:0] mem_rdata
);
   localparam int unsigned HI_W = ADDR_W - BYTE_W;
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   initial begin : chk_params
      assert (ADDR_W > BYTE_W && ADDR_W <= 2 * BYTE_W)
         else $error("spimem_ctrl: ADDR_W must fit in two address bytes");
   end

   // synchronized serial lines
   logic csn_s, sclk_s, mosi_s, holdn_s;
   spimem_sync #(
      .WIDTH     (4),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (4'b1001)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_csn, spi_sclk, spi_mosi, spi_holdn}),
      .q     ({csn_s, sclk_s, mosi_s, holdn_s})
   );

   // edge detection and hold latch (hold changes only while SCLK is low)
   logic sclk_q, held, go;
   logic frame_end, sclk_rise_e, sclk_fall_e;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         held   <= 1'b0;
      end else begin
         sclk_q <= sclk_s;
         if (!sclk_s) held <= !holdn_s;
      end
   end

   assign go          = !held;
   assign frame_end   = csn_s && go;
   assign sclk_rise_e = sclk_s && !sclk_q && go && !csn_s;
   assign sclk_fall_e = !sclk_s && sclk_q && go && !csn_s;

   // byte assembly
   logic              byte_vld;
   logic [BYTE_W-1:0] rx_byte;
   spimem_rx #(.BYTE_W(BYTE_W), .MSB_FIRST(1'b1)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (frame_end),
      .shift_en (sclk_rise_e),
      .din      (mosi_s),
      .byte_vld (byte_vld),
      .byte_q   (rx_byte)
   );

   // protocol state
   spimem_state_e     state;
   logic              in_frame, allow_frame, wel;
   logic              op_rd, op_fast, op_wr, wr_go;
   logic [HI_W-1:0]   addr_hi;
   logic [ADDR_W-1:0] addr, addr_full;
   logic              rd_r, rd_q, wr_r, oe_r;
   logic [ADDR_W-1:0] maddr_r;
   logic [BYTE_W-1:0] wdata_r;

   assign addr_full = {addr_hi, rx_byte};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_CMD;
         in_frame    <= 1'b0;
         allow_frame <= 1'b0;
         wel         <= 1'b0;
         op_rd       <= 1'b0;
         op_fast     <= 1'b0;
         op_wr       <= 1'b0;
         wr_go       <= 1'b0;
         addr_hi     <= '0;
         addr        <= '0;
         rd_r        <= 1'b0;
         rd_q        <= 1'b0;
         wr_r        <= 1'b0;
         oe_r        <= 1'b0;
         maddr_r     <= '0;
         wdata_r     <= '0;
      end else begin
         rd_r <= 1'b0;
         wr_r <= 1'b0;
         rd_q <= rd_r;
         if (frame_end) begin
            state    <= ST_CMD;
            in_frame <= 1'b0;
            oe_r     <= 1'b0;
            op_rd    <= 1'b0;
            op_wr    <= 1'b0;
            wr_go    <= 1'b0;
            if (op_wr) wel <= 1'b0;
         end else begin
            if (go && !in_frame) begin
               in_frame    <= 1'b1;
               allow_frame <= wr_allow;
            end
            if (sclk_fall_e && state == ST_RDATA) oe_r <= 1'b1;
            if (byte_vld) begin
               unique case (state)
                  ST_CMD: begin
                     unique case (rx_byte)
                        CMD_WREN: begin
                           wel   <= 1'b1;
                           state <= ST_SKIP;
                        end
                        CMD_READ: begin
                           op_rd   <= 1'b1;
                           op_fast <= 1'b0;
                           state   <= ST_AHI;
                        end
                        CMD_FREAD: begin
                           op_rd   <= 1'b1;
                           op_fast <= 1'b1;
                           state   <= ST_AHI;
                        end
                        CMD_WRITE: begin
                           op_wr <= 1'b1;
                           wr_go <= wel && allow_frame;
                           state <= ST_AHI;
                        end
                        default: state <= ST_SKIP;
                     endcase
                  end
                  ST_AHI: begin
                     addr_hi <= rx_byte[HI_W-1:0];
                     state   <= ST_ALO;
                  end
                  ST_ALO: begin
                     if (op_rd && !op_fast) begin
                        maddr_r <= addr_full;
                        rd_r    <= 1'b1;
                        addr    <= addr_full + ONE;
                        state   <= ST_RDATA;
                     end else if (op_rd) begin
                        addr  <= addr_full;
                        state <= ST_DUMMY;
                     end else begin
                        addr  <= addr_full;
                        state <= ST_WDATA;
                     end
                  end
                  ST_DUMMY, ST_RDATA: begin
                     maddr_r <= addr;
                     rd_r    <= 1'b1;
                     addr    <= addr + ONE;
                     state   <= ST_RDATA;
                  end
                  ST_WDATA: begin
                     if (wr_go) begin
                        maddr_r <= addr;
                        wdata_r <= rx_byte;
                        wr_r    <= 1'b1;
                     end
                     addr <= addr + ONE;
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   // serial output
   spimem_tx #(.BYTE_W(BYTE_W), .MSB_FIRST(1'b1)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (frame_end),
      .load      (rd_q),
      .load_data (mem_rdata),
      .shift     (sclk_fall_e && state == ST_RDATA),
      .dout      (spi_miso)
   );

   assign spi_miso_oe = oe_r && !held;
   assign mem_addr    = maddr_r;
   assign mem_rd      = rd_r;
   assign mem_wr      = wr_r;
   assign mem_wdata   = wdata_r;
endmodule

// File: rtl/spimem_ctrl_chk.sv
module spimem_ctrl_chk
   import spimem_pkg::*;
#(
   parameter int unsigned ADDR_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              spi_miso,
   input logic              spi_miso_oe,
   input logic              csn_s,
   input logic              held,
   input logic              sclk_fall_e,
   input spimem_state_e     state,
   input logic [ADDR_W-1:0] addr,
   input logic              wel,
   input logic              op_wr
);
   logic              seen;
   logic [ADDR_W-1:0] last_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen      <= 1'b0;
         last_addr <= '0;
      end else if (csn_s && !held) begin
         seen <= 1'b0;
      end else if (mem_rd || mem_wr) begin
         seen      <= 1'b1;
         last_addr <= mem_addr;
      end
   end

   assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   assert_strobe_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |=> !(mem_rd || mem_wr));

   assert_hold_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      held |=> ($stable(state) && $stable(addr)));

   assert_miso_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(spi_miso) && spi_miso_oe) |-> $past(sclk_fall_e));

   assert_skip_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |=> (!mem_rd && !mem_wr));

   assert_wel_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (csn_s && !held && op_wr) |=> !wel);

   assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || mem_wr) && seen) |-> (mem_addr == last_addr + ADDR_W'(1)));
endmodule

bind spimem_ctrl spimem_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mem_rd      (mem_rd),
   .mem_wr      (mem_wr),
   .mem_addr    (mem_addr),
   .spi_miso    (spi_miso),
   .spi_miso_oe (spi_miso_oe),
   .csn_s       (csn_s),
   .held        (held),
   .sclk_fall_e (sclk_fall_e),
   .state       (state),
   .addr        (addr),
   .wel         (wel),
   .op_wr       (op_wr)
);

// File: tb/tb_spimem_ctrl.sv
module tb_spimem_ctrl;
   localparam int HP = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csn = 1'b1, sclk = 1'b0, mosi = 1'b0, holdn = 1'b1, wr_allow = 1'b1;
   logic        miso, miso_oe, mem_rd, mem_wr;
   logic [14:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = 8'h00;

   int tests = 0;
   int fails = 0;
   int wr_n = 0;
   int rd_n = 0;
   logic [14:0] wl_a [64];
   logic [7:0]  wl_d [64];
   logic [7:0]  wbuf [8];

   always #2 clk = ~clk;

   spimem_ctrl dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .spi_csn     (csn),
      .spi_sclk    (sclk),
      .spi_mosi    (mosi),
      .spi_holdn   (holdn),
      .spi_miso    (miso),
      .spi_miso_oe (miso_oe),
      .wr_allow    (wr_allow),
      .mem_addr    (mem_addr),
      .mem_rd      (mem_rd),
      .mem_wr      (mem_wr),
      .mem_wdata   (mem_wdata),
      .mem_rdata   (mem_rdata)
   );

   function automatic logic [7:0] pat(input logic [14:0] a);
      return a[7:0] ^ {a[14:8], 1'b0} ^ 8'h5A;
   endfunction

   always @(posedge clk) begin
      if (mem_rd) begin
         mem_rdata <= pat(mem_addr);
         rd_n <= rd_n + 1;
      end
      if (mem_wr) begin
         if (wr_n < 64) begin
            wl_a[wr_n] <= mem_addr;
            wl_d[wr_n] <= mem_wdata;
         end
         wr_n <= wr_n + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_x(input logic o, output logic i, output logic oe);
      mosi = o;
      wait_n(HP);
      i = miso;
      oe = miso_oe;
      sclk = 1'b1;
      wait_n(HP);
      sclk = 1'b0;
   endtask

   task automatic byte_x(input logic [7:0] o, output logic [7:0] i, output logic oe_all);
      logic b, e;
      oe_all = 1'b1;
      for (int k = 7; k >= 0; k--) begin
         bit_x(o[k], b, e);
         i[k] = b;
         oe_all = oe_all & e;
      end
   endtask

   task automatic cs_start();
      csn = 1'b0;
      wait_n(HP);
   endtask

   task automatic cs_end();
      wait_n(HP);
      csn = 1'b1;
      wait_n(3 * HP);
   endtask

   task automatic send(input logic [7:0] o);
      logic [7:0] d;
      logic e;
      byte_x(o, d, e);
   endtask

   task automatic do_wren();
      cs_start();
      send(8'h06);
      cs_end();
   endtask

   task automatic do_read(input bit fast, input logic [14:0] a, input int n);
      logic [7:0] got;
      logic e;
      int w0;
      w0 = wr_n;
      cs_start();
      send(fast ? 8'h0B : 8'h03);
      send({1'($urandom), a[14:8]});
      send(a[7:0]);
      if (fast) send(8'($urandom));
      for (int k = 0; k < n; k++) begin
         logic [14:0] ak;
         ak = a + 15'(k);
         byte_x(8'($urandom), got, e);
         chk(fast ? "R2 fast read data" : "R1 read data", {24'h0, got}, {24'h0, pat(ak)});
         chk("R1 oe during data", {31'h0, e}, 32'h1);
      end
      cs_end();
      chk("R7 oe after cs rise", {31'h0, miso_oe}, 32'h0);
      chk("R10 no write during read", wr_n, w0);
   endtask

   task automatic do_write(input logic [14:0] a, input int n, input bit expect_en);
      cs_start();
      wr_n = 0;
      send(8'h02);
      send({1'b0, a[14:8]});
      send(a[7:0]);
      for (int k = 0; k < n; k++) send(wbuf[k]);
      cs_end();
      chk(expect_en ? "R4 write count" : "R5 write suppressed", wr_n, expect_en ? n : 0);
      if (expect_en) begin
         for (int k = 0; k < n && k < wr_n; k++) begin
            chk("R3 write address", {17'h0, wl_a[k]}, {17'h0, a + 15'(k)});
            chk("R4 write data", {24'h0, wl_d[k]}, {24'h0, wbuf[k]});
         end
      end
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      logic [7:0] got;
      logic e, b;
      int r0, w0;
      void'($urandom(32'h5EED_0042));
      wait_n(5);
      rst_n = 1'b1;
      wait_n(4);
      chk("R7 reset oe", {31'h0, miso_oe}, 32'h0);
      chk("R11 reset rd", {31'h0, mem_rd}, 32'h0);
      chk("R11 reset wr", {31'h0, mem_wr}, 32'h0);

      // directed reads and wrap
      do_read(1'b0, 15'h0123, 3);
      do_read(1'b1, 15'h4A5C, 2);
      do_read(1'b0, 15'h7FFE, 4);
      do_read(1'b1, 15'h7FFF, 2);

      // write without WREN: suppressed (R5)
      for (int k = 0; k < 8; k++) wbuf[k] = 8'($urandom);
      do_write(15'h0100, 2, 1'b0);

      // WREN then write with wrap (R3, R4, R6)
      do_wren();
      do_write(15'h7FFF, 3, 1'b1);
      // latch cleared by previous write frame (R6)
      do_write(15'h0200, 2, 1'b0);

      // allow low at frame start (R5)
      do_wren();
      wr_allow = 1'b0;
      wait_n(HP);
      do_write(15'h0300, 2, 1'b0);
      wr_allow = 1'b1;

      // allow drops mid-frame: no effect on this frame (R5)
      do_wren();
      cs_start();
      wr_n = 0;
      send(8'h02);
      wr_allow = 1'b0;
      send(8'h05);
      send(8'h55);
      send(8'hC3);
      cs_end();
      wr_allow = 1'b1;
      chk("R5 mid-frame allow change", wr_n, 1);
      chk("R5 mid-frame data", {24'h0, wl_d[0]}, 32'hC3);
      chk("R5 mid-frame addr", {17'h0, wl_a[0]}, 32'h0555);

      // partial byte discarded (R7)
      do_wren();
      cs_start();
      wr_n = 0;
      send(8'h02);
      send(8'h12);
      send(8'h34);
      send(8'h9E);
      for (int k = 0; k < 5; k++) bit_x(1'b1, b, e);
      cs_end();
      chk("R7 partial byte dropped", wr_n, 1);
      chk("R7 full byte kept", {24'h0, wl_d[0]}, 32'h9E);

      // unknown opcode (R8)
      r0 = rd_n;
      w0 = wr_n;
      do_wren();
      cs_start();
      send(8'hA5);
      for (int k = 0; k < 3; k++) begin
         byte_x(8'($urandom), got, e);
         chk("R8 oe stays low", {31'h0, e}, 32'h0);
      end
      cs_end();
      chk("R8 no read strobe", rd_n, r0);
      chk("R8 no write strobe", wr_n, w0);

      // hold during read data, with SCLK and CS toggling (R9)
      cs_start();
      send(8'h03);
      send(8'h21);
      send(8'h10);
      for (int k = 7; k >= 0; k--) begin
         if (k == 4) begin
            holdn = 1'b0;
            wait_n(HP);
            chk("R9 oe low in hold", {31'h0, miso_oe}, 32'h0);
            for (int t = 0; t < 3; t++) begin
               sclk = 1'b1; mosi = ~mosi; wait_n(HP);
               sclk = 1'b0; wait_n(HP);
            end
            csn = 1'b1; wait_n(HP);
            csn = 1'b0; wait_n(HP);
            holdn = 1'b1;
            wait_n(HP);
         end
         bit_x(1'b0, b, e);
         got[k] = b;
      end
      chk("R9 read resumes after hold", {24'h0, got}, {24'h0, pat(15'h2110)});
      byte_x(8'h00, got, e);
      chk("R9 next byte after hold", {24'h0, got}, {24'h0, pat(15'h2111)});
      cs_end();

      // hold during write data (R9)
      do_wren();
      cs_start();
      wr_n = 0;
      send(8'h02);
      send(8'h03);
      send(8'h40);
      for (int k = 7; k >= 0; k--) begin
         if (k == 2) begin
            holdn = 1'b0;
            wait_n(HP);
            for (int t = 0; t < 2; t++) begin
               sclk = 1'b1; mosi = 1'b1; wait_n(HP);
               sclk = 1'b0; mosi = 1'b0; wait_n(HP);
            end
            holdn = 1'b1;
            wait_n(HP);
         end
         bit_x(k[0], b, e);
      end
      cs_end();
      chk("R9 write count after hold", wr_n, 1);
      chk("R9 write data after hold", {24'h0, wl_d[0]}, 32'hAA);
      chk("R9 write addr after hold", {17'h0, wl_a[0]}, 32'h0340);

      // constrained random reads and writes
      for (int it = 0; it < 24; it++) begin
         logic [14:0] a;
         int n;
         a = 15'($urandom);
         if (($urandom % 4) == 0) a = 15'h7FFF - 15'($urandom % 3);
         n = 1 + int'($urandom % 4);
         if (($urandom % 2) == 0) begin
            do_read(1'($urandom), a, n);
         end else begin
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            do_wren();
            do_write(a, n, 1'b1);
         end
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule